// File: doc/BRIEF.md
# Serial-Loaded Latched Switch Controller

This block turns a serial bit stream into eight switch-enable lines. Bits arrive on `ser_in` and move through a shift chain one stage per `step` strobe. The last stage is driven out on `ser_out`, so several controllers can be cascaded on one serial line. A holding latch sits between the shift chain and the switch-enable outputs.

While `hold` is low, the latch is transparent and the outputs follow the shift chain. While `hold` is high, the outputs stay frozen, so a new pattern can be shifted in without disturbing the switches. Software raises `hold` and shifts in a full pattern. It then drops `hold` for at least one cycle to publish the pattern and raises it again.

`clr` is an active-high override. It turns every output off in the same cycle. At the next clock edge it also empties the shift chain and the latch, so the outputs stay off until new data is shifted in.

The block runs on one system clock with a synchronous active-high reset. The serial clock is presented as a one-cycle `step` strobe, one per rising edge of the serial clock.

Top module: `swc_serial_switch_ctrl`

## Requirements
- R1: After reset, every bit of `sw_on` is 0 (OFF) and `ser_out` is 0.
- R2: At a clock edge with `step` high, `ser_in` enters stage 0 and every stage i moves to stage i+1. After eight steps, the first bit shifted in sits in stage 7 and the last bit in stage 0. With `step` low, the stages keep their values.
- R3: `ser_out` is 1 exactly when stage 7 holds 1, which is the bit that entered eight steps earlier.
- R4: While `hold` is low and `clr` is low, `sw_on[i]` equals stage i (1 = switch ON, 0 = OFF) in the same cycle the stage changes.
- R5: While `hold` stays high and `clr` is low, `sw_on` keeps the value it had when `hold` rose, whatever `step` and `ser_in` do. `ser_out` keeps shifting.
- R6: While `clr` is high, every bit of `sw_on` is 0 in the same cycle, whatever the other inputs are.
- R7: A clock edge with `clr` high empties the shift chain and the latch. Afterwards `ser_out` is 0 and `sw_on` is 0 until new bits are shifted in, whether `hold` is high or low.
- R8: Each output bit depends only on its own stage. Any pattern of ones and zeros appears unchanged on the eight outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_in | input | 1 | Serial data bit |
| step | input | 1 | One-cycle strobe that shifts the chain by one stage |
| hold | input | 1 | 1 freezes the outputs, 0 makes the latch transparent |
| clr | input | 1 | Active-high override: all outputs off, chain emptied |
| sw_on | output | NCH | Switch enables, bit i for channel i, 1 = ON |
| ser_out | output | 1 | Last stage of the shift chain, for cascading |

## Verification
A corrupted shift stage shows up on `ser_out` within at most eight steps. When `hold` is low, it also shows on the matching `sw_on` bit in the same cycle. A latch that fails to freeze changes `sw_on` on the first step taken while `hold` is high. A clear that misses the chain or the latch shows up as a 1 on `ser_out` or `sw_on` in the cycle right after `clr` is released. The bench compares every cycle with a reference that models the latch as a level-sensitive element. It checks the cascade output against a history of the last nine bits shifted in.

// File: rtl/swc_pkg.sv
package swc_pkg;

    localparam int CH_COUNT = 8;

    // Inputs of one control cycle, gathered for the datapath
    typedef struct packed {
        logic ser;
        logic step;
        logic hold;
        logic clr;
    } swc_ctl_t;

    // How the holding latch behaves in the current cycle
    typedef enum logic [1:0] {
        LAT_CLEAR  = 2'd0,
        LAT_FOLLOW = 2'd1,
        LAT_FREEZE = 2'd2
    } lat_mode_t;

    // Clear beats hold; hold low means transparent
    function automatic lat_mode_t lat_mode(swc_ctl_t c);
        if (c.clr)       return LAT_CLEAR;
        else if (c.hold) return LAT_FREEZE;
        else             return LAT_FOLLOW;
    endfunction

endpackage

// File: rtl/swc_shift_chain.sv
module swc_shift_chain
    import swc_pkg::*;
#(
    parameter int NCH = CH_COUNT
) (
    input  logic           clk,
    input  logic           rst,
    input  swc_ctl_t       ctl,
    output logic [NCH-1:0] stage_q,
    output logic [NCH-1:0] stage_d
);

    // Next-state of each stage; stage 0 takes the serial bit
    for (genvar i = 0; i < NCH; i++) begin : g_stage
        if (i == 0) begin : g_head
            always_comb begin
                if (ctl.clr)       stage_d[i] = 1'b0;
                else if (ctl.step) stage_d[i] = ctl.ser;
                else               stage_d[i] = stage_q[i];
            end
        end else begin : g_body
            always_comb begin
                if (ctl.clr)       stage_d[i] = 1'b0;
                else if (ctl.step) stage_d[i] = stage_q[i-1];
                else               stage_d[i] = stage_q[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) stage_q <= '0;
        else     stage_q <= stage_d;
    end

endmodule

// File: rtl/swc_hold_latch.sv
module swc_hold_latch
    import swc_pkg::*;
#(
    parameter int NCH = CH_COUNT
) (
    input  logic           clk,
    input  logic           rst,
    input  lat_mode_t      mode,
    input  logic [NCH-1:0] stage_q,
    input  logic [NCH-1:0] stage_d,
    output logic [NCH-1:0] sw_on
);

    // The frozen copy tracks the post-edge chain value, so raising hold
    // mid-cycle shows exactly what the outputs already present.
    logic [NCH-1:0] frozen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            frozen_q <= '0;
        end else begin
            unique case (mode)
                LAT_CLEAR:  frozen_q <= '0;
                LAT_FOLLOW: frozen_q <= stage_d;
                default:    frozen_q <= frozen_q;
            endcase
        end
    end

    always_comb begin
        unique case (mode)
            LAT_CLEAR:  sw_on = '0;
            LAT_FOLLOW: sw_on = stage_q;
            default:    sw_on = frozen_q;
        endcase
    end

endmodule

// File: rtl/swc_serial_switch_ctrl.sv
module swc_serial_switch_ctrl
    import swc_pkg::*;
#(
    parameter int NCH = CH_COUNT
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           ser_in,
    input  logic           step,
    input  logic           hold,
    input  logic           clr,
    output logic [NCH-1:0] sw_on,
    output logic           ser_out
);

    localparam int LAST = NCH - 1;

    swc_ctl_t       ctl;
    lat_mode_t      mode;
    logic [NCH-1:0] stage_q;
    logic [NCH-1:0] stage_d;

    always_comb begin
        ctl.ser  = ser_in;
        ctl.step = step;
        ctl.hold = hold;
        ctl.clr  = clr;
        mode     = lat_mode(ctl);
    end

    swc_shift_chain #(.NCH(NCH)) chain_i (
        .clk     (clk),
        .rst     (rst),
        .ctl     (ctl),
        .stage_q (stage_q),
        .stage_d (stage_d)
    );

    swc_hold_latch #(.NCH(NCH)) latch_i (
        .clk     (clk),
        .rst     (rst),
        .mode    (mode),
        .stage_q (stage_q),
        .stage_d (stage_d),
        .sw_on   (sw_on)
    );

    assign ser_out = stage_q[LAST];

endmodule

// File: rtl/swc_serial_switch_ctrl_chk.sv
module swc_serial_switch_ctrl_chk #(
    parameter int NCH = 8
) (
    input logic           clk,
    input logic           rst,
    input logic           ser_in,
    input logic           step,
    input logic           hold,
    input logic           clr,
    input logic [NCH-1:0] sw_on,
    input logic           ser_out
);

    p_clear_off_r6: assert property (@(posedge clk) disable iff (rst)
        clr |-> (sw_on == '0));

    p_cascade_tap_r3: assert property (@(posedge clk) disable iff (rst)
        (!clr && !hold) |-> (ser_out == sw_on[NCH-1]));

    p_shift_follow_r4: assert property (@(posedge clk) disable iff (rst)
        (!hold && !clr && step) |=>
            (hold || clr || sw_on == {$past(sw_on[NCH-2:0]), $past(ser_in)}));

    p_freeze_r5: assert property (@(posedge clk) disable iff (rst)
        (hold && !clr && $past(hold) && !$past(clr) && !$past(rst)) |-> $stable(sw_on));

    p_after_clear_r7: assert property (@(posedge clk) disable iff (rst)
        $past(clr) |-> (ser_out == 1'b0 && (clr || sw_on == '0)));

endmodule

bind swc_serial_switch_ctrl swc_serial_switch_ctrl_chk #(.NCH(NCH)) chk_i (
    .clk     (clk),
    .rst     (rst),
    .ser_in  (ser_in),
    .step    (step),
    .hold    (hold),
    .clr     (clr),
    .sw_on   (sw_on),
    .ser_out (ser_out)
);

// File: tb/swc_serial_switch_ctrl_tb_top.sv
module swc_serial_switch_ctrl_tb_top;

    localparam int NCH = 8;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           ser_in = 1'b0;
    logic           step = 1'b0;
    logic           hold = 1'b0;
    logic           clr = 1'b0;
    logic [NCH-1:0] sw_on;
    logic           ser_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // reference state
    logic [NCH-1:0] m_sreg = '0;
    logic [NCH-1:0] m_lat  = '0;
    logic [NCH:0]   m_hist = '0;   // nine-bit history of shifted bits

    swc_serial_switch_ctrl #(.NCH(NCH)) dut_i (
        .clk     (clk),
        .rst     (rst),
        .ser_in  (ser_in),
        .step    (step),
        .hold    (hold),
        .clr     (clr),
        .sw_on   (sw_on),
        .ser_out (ser_out)
    );

    always #2.5 clk = ~clk;

    function automatic logic [NCH-1:0] exp_sw(logic c, logic h,
                                              logic [NCH-1:0] s, logic [NCH-1:0] l);
        if (c)      return '0;
        else if (h) return l;
        else        return s;
    endfunction

    task automatic chk(string req, logic [NCH-1:0] act, logic [NCH-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // level-sensitive latch update of the reference
    task automatic lat_eval();
        if (clr)        m_lat = '0;
        else if (!hold) m_lat = m_sreg;
    endtask

    task automatic outputs_check(string req);
        chk(req, sw_on, exp_sw(clr, hold, m_sreg, m_lat));
        chk("R3", {{(NCH-1){1'b0}}, ser_out}, {{(NCH-1){1'b0}}, m_hist[NCH-1]});
    endtask

    // one cycle: apply inputs just after an edge, check, clock, check
    task automatic cyc(string req, logic s, logic st, logic h, logic c);
        ser_in = s; step = st; hold = h; clr = c;
        #1;
        lat_eval();
        outputs_check(req);
        @(posedge clk);
        if (c) begin
            m_sreg = '0;
            m_hist = '0;
        end else if (st) begin
            m_sreg = {m_sreg[NCH-2:0], s};
            m_hist = {m_hist[NCH-1:0], s};
        end
        lat_eval();
        #1;
        outputs_check(req);
    endtask

    task automatic load(string req, logic [NCH-1:0] pat, logic h);
        for (int i = NCH - 1; i >= 0; i--) cyc(req, pat[i], 1'b1, h, 1'b0);
    endtask

    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_2a71));
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        #1;
        chk("R1", sw_on, '0);
        chk("R1", {{(NCH-1){1'b0}}, ser_out}, '0);

        // R5: load under hold, outputs stay at the reset value
        load("R5", 8'b1011_0010, 1'b1);
        cyc("R5", 1'b1, 1'b0, 1'b1, 1'b0);
        // R4: publish by dropping hold
        cyc("R4", 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R2", sw_on, 8'b1011_0010);       // first bit shifted in now on channel 7
        // R2: idle cycles without a step keep the chain
        cyc("R2", 1'b1, 1'b0, 1'b0, 1'b0);
        cyc("R2", 1'b0, 1'b0, 1'b0, 1'b0);
        // R5: freeze then shift a different pattern
        cyc("R5", 1'b0, 1'b0, 1'b1, 1'b0);
        load("R5", 8'b0100_1101, 1'b1);
        chk("R5", sw_on, 8'b1011_0010);
        cyc("R4", 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R8", sw_on, 8'b0100_1101);
        // R8: single-channel patterns
        for (int k = 0; k < NCH; k++) begin
            load("R8", 8'(1 << k), 1'b0);
            chk("R8", sw_on, 8'(1 << k));
        end
        load("R8", 8'b1111_1111, 1'b0);
        // R6: clear with hold low and high
        cyc("R6", 1'b1, 1'b1, 1'b0, 1'b1);
        cyc("R7", 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R7", sw_on, '0);
        load("R4", 8'b1110_0111, 1'b0);
        cyc("R5", 1'b0, 1'b0, 1'b1, 1'b0);
        cyc("R6", 1'b1, 1'b1, 1'b1, 1'b1);
        cyc("R7", 1'b0, 1'b0, 1'b1, 1'b0);
        chk("R7", sw_on, '0);
        cyc("R7", 1'b0, 1'b0, 1'b0, 1'b0);

        // constrained random traffic
        for (int n = 0; n < 4000; n++) begin
            logic rs, rst_p, rh, rc;
            rs    = 1'($urandom);
            rst_p = ($urandom % 2) == 0;
            rh    = ($urandom % 3) == 0;
            rc    = ($urandom % 24) == 0;
            cyc("R4", rs, rst_p, rh, rc);
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

endmodule